// File: doc/BRIEF.md
# Bus Master Transfer-Type Sequencer

This block sits between a cache-style client and a shared system bus whose transfers are typed as address-only, nonsequential or sequential. The client hands it one request at a time: a single read, a single write, a four-word line fill or a four-word write-back of an evicted or cleaned line. The sequencer turns each request into a series of typed bus cycles. It drives the transfer-type code, the word address, a direction flag and a burst-length indication.

Every request begins with one address-only lead cycle. During that cycle a look-ahead strobe warns the memory controller that real data cycles follow, provided grant is high at the closing clock edge. This lets the controller tell plain idle cycles apart from the address phase of a committed transfer. If grant is low at that edge, the sequencer falls back to address-only cycles with the strobe low. When grant returns, it repeats the lead cycle and restarts from the first beat.

Bursts start at the critical word the client asked for. The address then steps one word per beat, wrapping inside the 16-byte line. A wait input stalls any data cycle. A one-cycle done pulse marks the end of each request.

Top module: `bseq_top`

## Requirements
- R1: The transfer-type output only ever takes the values 2'b00 (address-only), 2'b10 (nonsequential) or 2'b11 (sequential). The value 2'b01 is never driven.
- R2: After reset and whenever idle, the block drives 2'b00 with the strobe low, burst length 2'b00, done low and req_ready high.
- R3: req_kind bit 1 set means a four-word burst and bit 0 set means a write. The first data beat is typed 2'b10 and carries req_addr with its two low bits cleared. xfer_write equals req_kind bit 0 for the whole request.
- R4: A burst has exactly four data beats. Beats after the first are typed 2'b11, and each address is the previous one plus 4, wrapping within the 16-byte aligned line (only bits 3:2 change). burst_len is 2'b01 from the lead cycle through the last beat of a burst. A single transfer has one data beat and burst_len 2'b00.
- R5: The strobe is high only in the address-only lead cycle that follows acceptance of a request, and again after each retry. It is never high in a data cycle, a retry cycle or a plain idle cycle.
- R6: If grant is high at the edge that ends a lead cycle, the first data beat is driven in the next cycle. Grant is sampled only at the end of lead and retry cycles and is ignored during data cycles.
- R7: If grant is low at the edge that ends a lead cycle, the next cycles are address-only with the strobe low until grant is high at an edge. The block then repeats the lead cycle (strobe high) and restarts from the first beat's address.
- R8: While bus_wait is high in a data cycle, the type, address and strobe hold and the beat does not advance. bus_wait has no effect in lead, retry or idle cycles.
- R9: done is high for exactly one cycle, in the cycle after the last data beat completes with bus_wait low.
- R10: A request is accepted only while req_ready is high (idle). req_valid and request fields presented at other times are ignored and start no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client presents a request |
| req_kind | input | 2 | Bit 1: four-word burst; bit 0: write |
| req_addr | input | AW | Byte address of the critical word |
| req_ready | output | 1 | High while idle; request taken when both valid and ready |
| bus_grant | input | 1 | Bus grant, sampled at the end of lead and retry cycles |
| bus_wait | input | 1 | Stalls the current data cycle |
| xfer_type | output | 2 | Transfer-type code (00 address-only, 10 nonsequential, 11 sequential) |
| xfer_addr | output | AW | Word address of the current cycle |
| xfer_write | output | 1 | Direction of the current request |
| burst_len | output | 2 | 01 for a four-word burst, 00 for a single |
| ahead_strobe | output | 1 | Look-ahead strobe in the lead cycle |
| done | output | 1 | One-cycle pulse after the last beat |

## Verification
On every cycle, the assertions check these properties:
- the reserved type code never appears;
- the strobe is high only in address-only cycles;
- a granted lead cycle is followed by a nonsequential beat, and an ungranted one by an address-only cycle with the strobe low;
- a waited data cycle holds its type and address;
- each sequential beat's address is the wrapped increment of the one before;
- done never lasts two cycles.

Some properties need the whole request in view, so only the bench scenarios can show them:
- the right number of beats per request kind;
- the critical-word start and the wrap order across the line;
- restart from the first beat after several retries;
- stray requests outside idle being dropped;
- grant and wait being ignored in the cycles where they have no meaning.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_HOLD = 2'd2,
        ST_DATA = 2'd3
    } bseq_state_e;

    localparam logic [1:0] TT_ADDR_ONLY = 2'b00;
    localparam logic [1:0] TT_NONSEQ    = 2'b10;
    localparam logic [1:0] TT_SEQ       = 2'b11;

    localparam logic [1:0] BL_SINGLE    = 2'b00;
    localparam logic [1:0] BL_LINE      = 2'b01;

    localparam int unsigned KIND_BURST_BIT = 1;
    localparam int unsigned KIND_WRITE_BIT = 0;

endpackage

// File: rtl/bseq_wrap_inc.sv
module bseq_wrap_inc #(
    parameter int unsigned AW         = 32,
    parameter int unsigned BEATS      = 4,
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_o
);
    localparam int unsigned OFF_LSB = $clog2(WORD_BYTES);
    localparam int unsigned BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int unsigned HI_LSB  = OFF_LSB + BEAT_W;

    generate
        if (BEATS > 1) begin : g_wrap
            logic [BEAT_W-1:0] idx_d;
            always_comb begin
                idx_d  = addr_i[HI_LSB-1:OFF_LSB] + BEAT_W'(1);
                addr_o = {addr_i[AW-1:HI_LSB], idx_d, addr_i[OFF_LSB-1:0]};
            end
        end else begin : g_pass
            always_comb addr_o = addr_i;
        end
    endgenerate

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
    parameter int unsigned BEATS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     adv_i,
    output logic [((BEATS > 1) ? $clog2(BEATS) : 1)-1:0] beat_o,
    output logic                     last_o
);
    localparam int unsigned BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BEATS - 1);

    logic [BEAT_W-1:0] beat_d, beat_q;

    always_comb begin
        beat_d = beat_q;
        if (clear_i) begin
            beat_d = '0;
        end else if (adv_i && (beat_q != LAST_IDX)) begin
            beat_d = beat_q + BEAT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    assign beat_o = beat_q;
    assign last_o = (beat_q == LAST_IDX);

    a_r4_beat_stops_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !clear_i) |=> last_o)
        else $error("beat counter left the last beat without a clear");

endmodule

// File: rtl/bseq_top.sv
module bseq_top
    import bseq_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned BEATS      = 4,
    parameter int unsigned WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    input  logic          bus_grant,
    input  logic          bus_wait,
    output logic [1:0]    xfer_type,
    output logic [AW-1:0] xfer_addr,
    output logic          xfer_write,
    output logic [1:0]    burst_len,
    output logic          ahead_strobe,
    output logic          done
);
    localparam int unsigned OFF_LSB = $clog2(WORD_BYTES);
    localparam int unsigned BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int unsigned HI_LSB  = OFF_LSB + BEAT_W;

    typedef struct packed {
        bseq_state_e   st;
        logic [AW-1:0] addr;
        logic          write;
        logic          burst;
        logic          done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              ctr_clear, ctr_adv;
    logic [BEAT_W-1:0] beat_idx;
    logic              beat_last;
    logic [AW-1:0]     addr_next;
    logic              unused_lsbs;

    assign unused_lsbs = ^req_addr[OFF_LSB-1:0];

    bseq_wrap_inc #(
        .AW         (AW),
        .BEATS      (BEATS),
        .WORD_BYTES (WORD_BYTES)
    ) u_inc (
        .addr_i (ctl_q.addr),
        .addr_o (addr_next)
    );

    bseq_beat_ctr #(
        .BEATS (BEATS)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (ctr_clear),
        .adv_i   (ctr_adv),
        .beat_o  (beat_idx),
        .last_o  (beat_last)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctr_clear  = 1'b0;
        ctr_adv    = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.st    = ST_LEAD;
                    ctl_d.addr  = {req_addr[AW-1:OFF_LSB], {OFF_LSB{1'b0}}};
                    ctl_d.write = req_kind[KIND_WRITE_BIT];
                    ctl_d.burst = req_kind[KIND_BURST_BIT];
                    ctr_clear   = 1'b1;
                end
            end
            ST_LEAD: begin
                ctl_d.st = bus_grant ? ST_DATA : ST_HOLD;
            end
            ST_HOLD: begin
                if (bus_grant) begin
                    ctl_d.st = ST_LEAD;
                end
            end
            ST_DATA: begin
                if (!bus_wait) begin
                    if (!ctl_q.burst || beat_last) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.addr = addr_next;
                        ctr_adv    = 1'b1;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, addr: '0, write: 1'b0, burst: 1'b0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        if (ctl_q.st == ST_DATA) begin
            xfer_type = (beat_idx == '0) ? TT_NONSEQ : TT_SEQ;
        end else begin
            xfer_type = TT_ADDR_ONLY;
        end
    end

    assign xfer_addr    = ctl_q.addr;
    assign xfer_write   = ctl_q.write;
    assign burst_len    = (ctl_q.st != ST_IDLE && ctl_q.burst) ? BL_LINE : BL_SINGLE;
    assign ahead_strobe = (ctl_q.st == ST_LEAD);
    assign done         = ctl_q.done;
    assign req_ready    = (ctl_q.st == ST_IDLE);

    // R1
    a_r1_no_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_type != 2'b01)
        else $error("reserved transfer type driven");

    // R5
    a_r5_strobe_addr_only: assert property (@(posedge clk) disable iff (!rst_n)
        ahead_strobe |-> (xfer_type == TT_ADDR_ONLY))
        else $error("strobe outside an address-only cycle");

    // R6
    a_r6_grant_starts_data: assert property (@(posedge clk) disable iff (!rst_n)
        (ahead_strobe && bus_grant) |=> (xfer_type == TT_NONSEQ))
        else $error("granted lead cycle not followed by nonsequential beat");

    // R7
    a_r7_no_grant_backs_off: assert property (@(posedge clk) disable iff (!rst_n)
        (ahead_strobe && !bus_grant) |=> (!ahead_strobe && xfer_type == TT_ADDR_ONLY))
        else $error("ungranted lead cycle did not back off");

    // R8
    a_r8_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_type != TT_ADDR_ONLY && bus_wait) |=>
            ($stable(xfer_type) && $stable(xfer_addr) && !ahead_strobe))
        else $error("data cycle changed under wait");

    // R4
    a_r4_seq_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_type == TT_SEQ && !$past(bus_wait)) |->
            (xfer_addr[AW-1:HI_LSB] == $past(xfer_addr[AW-1:HI_LSB]) &&
             xfer_addr[HI_LSB-1:OFF_LSB] == BEAT_W'($past(xfer_addr[HI_LSB-1:OFF_LSB]) + 1'b1)))
        else $error("sequential address not the wrapped increment");

    // R9
    a_r9_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done held longer than one cycle");

endmodule

// File: tb/tb_bseq_top.sv
`timescale 1ns/1ps
module tb_bseq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic        bus_grant = 1'b0;
    logic        bus_wait = 1'b0;
    logic [1:0]  xfer_type;
    logic [31:0] xfer_addr;
    logic        xfer_write;
    logic [1:0]  burst_len;
    logic        ahead_strobe;
    logic        done;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bseq_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_ready(req_ready), .bus_grant(bus_grant),
        .bus_wait(bus_wait), .xfer_type(xfer_type), .xfer_addr(xfer_addr),
        .xfer_write(xfer_write), .burst_len(burst_len),
        .ahead_strobe(ahead_strobe), .done(done)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] exp_addr(input logic [31:0] a, input int b);
        logic [1:0] w;
        w = a[3:2] + 2'(b);
        return {a[31:4], w, 2'b00};
    endfunction

    task automatic check_idle(input string req);
        chk(req, "type idle", 32'(xfer_type), 32'h0);
        chk(req, "strobe idle", 32'(ahead_strobe), 32'h0);
        chk(req, "burst_len idle", 32'(burst_len), 32'h0);
        chk(req, "ready idle", 32'(req_ready), 32'h1);
    endtask

    task automatic do_xfer(input logic [1:0] kind, input logic [31:0] a,
                           input int retries, input int wait_pct);
        int         nb;
        logic [1:0] bl;
        nb = kind[1] ? 4 : 1;
        bl = kind[1] ? 2'b01 : 2'b00;
        chk("R10", "ready before request", 32'(req_ready), 32'h1);
        req_valid = 1'b1;
        req_kind  = kind;
        req_addr  = a;
        bus_grant = 1'b0;
        step();
        // stray request content while busy (R10)
        req_kind = ~kind;
        req_addr = ~a;
        for (int r = 0; r <= retries; r++) begin
            chk("R5", "strobe in lead", 32'(ahead_strobe), 32'h1);
            chk("R1", "type in lead", 32'(xfer_type), 32'h0);
            chk("R4", "burst_len in lead", 32'(burst_len), 32'(bl));
            chk("R10", "ready busy", 32'(req_ready), 32'h0);
            chk("R3", "lead addr", xfer_addr, exp_addr(a, 0));
            bus_wait = 1'($urandom % 2);
            if (r < retries) begin
                bus_grant = 1'b0;
                step();
                chk("R7", "strobe after no grant", 32'(ahead_strobe), 32'h0);
                chk("R7", "type after no grant", 32'(xfer_type), 32'h0);
                for (int e = 0; e < int'($urandom % 3); e++) begin
                    step();
                    chk("R7", "retry strobe low", 32'(ahead_strobe), 32'h0);
                    chk("R7", "retry type", 32'(xfer_type), 32'h0);
                end
                bus_grant = 1'b1;
                step();
            end else begin
                bus_grant = 1'b1;
                step();
            end
        end
        for (int b = 0; b < nb; b++) begin
            bus_grant = 1'($urandom % 2);
            if (b == nb - 1) req_valid = 1'b0;
            chk(b == 0 ? "R3" : "R4", "beat type", 32'(xfer_type),
                b == 0 ? 32'h2 : 32'h3);
            chk(b == 0 ? "R3" : "R4", "beat addr", xfer_addr, exp_addr(a, b));
            chk("R3", "write flag", 32'(xfer_write), 32'(kind[0]));
            chk("R4", "burst_len beat", 32'(burst_len), 32'(bl));
            chk("R5", "strobe in data", 32'(ahead_strobe), 32'h0);
            chk("R9", "done mid", 32'(done), 32'h0);
            while (int'($urandom % 100) < wait_pct) begin
                bus_wait = 1'b1;
                step();
                chk("R8", "type held", 32'(xfer_type), b == 0 ? 32'h2 : 32'h3);
                chk("R8", "addr held", xfer_addr, exp_addr(a, b));
            end
            bus_wait = 1'b0;
            step();
        end
        chk("R9", "done pulse", 32'(done), 32'h1);
        chk("R2", "type after last", 32'(xfer_type), 32'h0);
        chk("R2", "ready after last", 32'(req_ready), 32'h1);
        step();
        chk("R9", "done cleared", 32'(done), 32'h0);
        chk("R10", "no stray transfer", 32'(ahead_strobe), 32'h0);
        check_idle("R2");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R2");
        chk("R9", "done at reset", 32'(done), 32'h0);
        // plain idle with grant and wait toggling (R5, R8)
        bus_grant = 1'b1;
        bus_wait = 1'b1;
        repeat (3) begin
            step();
            chk("R5", "idle strobe", 32'(ahead_strobe), 32'h0);
            chk("R8", "idle type under wait", 32'(xfer_type), 32'h0);
        end
        bus_wait = 1'b0;
        do_xfer(2'b00, 32'h0000_1238, 0, 0);
        do_xfer(2'b01, 32'h0000_2001, 0, 0);
        do_xfer(2'b10, 32'h0000_300C, 0, 0);
        do_xfer(2'b11, 32'h0000_4000, 0, 0);
        do_xfer(2'b10, 32'h0000_5004, 2, 0);
        do_xfer(2'b11, 32'h0000_6008, 1, 60);
        do_xfer(2'b01, 32'h0000_7ffc, 3, 50);
        for (int i = 0; i < 40; i++) begin
            do_xfer(2'($urandom), $urandom, int'($urandom % 3), int'($urandom % 50));
            repeat (int'($urandom % 3)) begin
                step();
                chk("R5", "gap strobe", 32'(ahead_strobe), 32'h0);
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule